// File: doc/BRIEF.md
# Branch Target Address Selector with Return Stack

This block holds the processor's next program address and decides where it comes from. The address register can load from three places. The first is the H/L register pair, which every ordinary memory reference uses. The second is a temporary register that collects the inline address bytes of a jump or call. The third is a small hardware return stack.

A call pushes the current program counter onto the return stack. A return pops the saved address and loads it back into the address register. An up/down pointer tracks the stack position. The pointer wraps around the stack depth and raises no overflow or underflow flag.

The surrounding sequencer keeps the inline-byte capture running for every opcode. It only chooses between jump, call and return in a later stage. It drives the source select and the push/pop strobes from that later decision. Opcode decode, fetch timing and the memory data path stay outside the block.

Top module: `branch_addr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `addr_out` and `stk_ptr` both become 0 at that edge. Reset takes priority over every other request.
- R2: With `load_en` high and `src_sel` = 2'b00, the next edge loads `addr_out` with {`hl_h`[4:0], `hl_l`}. The upper three bits of `hl_h` are dropped.
- R3: `inl_lo_we` captures `inl_byte` as the temporary low byte. `inl_hi_we` captures `inl_byte`[4:0] as the temporary high bits. With `load_en` high and `src_sel` = 2'b01, `addr_out` loads the temporary value as it stood before that edge. Each half changes only on its own strobe.
- R4: `push_req` writes `pc_in` into the stack entry at `stk_ptr` and increments `stk_ptr` by one. With no push or pop, `stk_ptr` holds.
- R5: `pop_req` without `push_req` decrements `stk_ptr`. With `load_en` high and `src_sel` = 2'b10, `addr_out` loads the entry just below `stk_ptr` as it stood before the edge, so a return pops the most recently pushed address.
- R6: The pointer wraps modulo the depth of 8. A ninth push returns `stk_ptr` to 1 and overwrites entry 0. A pop from 0 goes to 7. No flag is raised.
- R7: When `push_req` and `pop_req` are both high, the push wins: `stk_ptr` increments and the pop is ignored.
- R8: With `load_en` low, or with `src_sel` = 2'b11, `addr_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hl_h | input | 8 | H register byte (upper address bits) |
| hl_l | input | 8 | L register byte (lower address bits) |
| inl_byte | input | 8 | Inline address byte from the instruction stream |
| inl_lo_we | input | 1 | Capture `inl_byte` as the temporary low byte |
| inl_hi_we | input | 1 | Capture `inl_byte` as the temporary high bits |
| pc_in | input | 13 | Current program counter, pushed on a call |
| push_req | input | 1 | Push `pc_in` onto the return stack |
| pop_req | input | 1 | Pop the return stack |
| src_sel | input | 2 | 00 H/L, 01 temporary register, 10 stack top, 11 none |
| load_en | input | 1 | Load the address register from the selected source |
| addr_out | output | 13 | Address register |
| stk_ptr | output | 3 | Return-stack pointer |

## Verification
The assertions check the pointer arithmetic on every cycle: increment on push, decrement on a lone pop, hold when idle, wrap at the top, and push priority. On every cycle they also check the reset clear, the H/L load, the hold of the address register and the push-then-return round trip. Other behaviours need the bench's scenarios and its reference model. These are last-in-first-out ordering across several nested pushes, the independence of the two temporary-register halves, and the overwrite of the oldest entry after a wrap. They also include the rule that a load sees the temporary or stack contents from before the same edge.

// File: rtl/br_pkg.sv
package br_pkg;
   typedef enum logic [1:0] {
      SRC_HL   = 2'b00,
      SRC_TMP  = 2'b01,
      SRC_STK  = 2'b10,
      SRC_NONE = 2'b11
   } src_sel_e;
endpackage

// File: rtl/br_ret_stack.sv
module br_ret_stack #(
   parameter int AW    = 13,
   parameter int DEPTH = 8,
   parameter int PW    = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   input  logic [AW-1:0] wdata,
   output logic [AW-1:0] top,
   output logic [PW-1:0] ptr
);
   localparam bit POW2 = ((1 << PW) == DEPTH);

   logic [AW-1:0] mem [DEPTH];
   logic [PW-1:0] ptr_q, ptr_up, ptr_dn;

   generate
      if (POW2) begin : g_wrap_free
         assign ptr_up = ptr_q + PW'(1);
         assign ptr_dn = ptr_q - PW'(1);
      end else begin : g_wrap_cmp
         assign ptr_up = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + PW'(1);
         assign ptr_dn = (ptr_q == '0) ? PW'(DEPTH - 1) : ptr_q - PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) ptr_q <= '0;
      else if (push) ptr_q <= ptr_up;
      else if (pop) ptr_q <= ptr_dn;
   end

   always_ff @(posedge clk) begin
      if (!rst && push) mem[ptr_q] <= wdata;
   end

   assign top = mem[ptr_dn];
   assign ptr = ptr_q;
endmodule

// File: rtl/br_tmp_addr.sv
module br_tmp_addr #(
   parameter int AW = 13,
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic [BW-1:0] byte_in,
   input  logic          lo_we,
   input  logic          hi_we,
   output logic [AW-1:0] value
);
   localparam int HW = AW - BW;

   logic [BW-1:0] lo_q;
   logic [HW-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (lo_we) lo_q <= byte_in;
      if (hi_we) hi_q <= byte_in[HW-1:0];
   end

   assign value = {hi_q, lo_q};
endmodule

// File: rtl/br_src_mux.sv
module br_src_mux
   import br_pkg::*;
#(
   parameter int AW    = 13,
   parameter int STYLE = 0
) (
   input  src_sel_e      sel,
   input  logic [AW-1:0] hl,
   input  logic [AW-1:0] tmp,
   input  logic [AW-1:0] stk,
   output logic [AW-1:0] nxt,
   output logic          take
);
   assign take = (sel != SRC_NONE);

   generate
      if (STYLE == 0) begin : g_case
         always_comb begin
            case (sel)
               SRC_HL:  nxt = hl;
               SRC_TMP: nxt = tmp;
               SRC_STK: nxt = stk;
               default: nxt = '0;
            endcase
         end
      end else begin : g_andor
         logic s_hl, s_tmp, s_stk;
         assign s_hl  = (sel == SRC_HL);
         assign s_tmp = (sel == SRC_TMP);
         assign s_stk = (sel == SRC_STK);
         assign nxt = ({AW{s_hl}} & hl) | ({AW{s_tmp}} & tmp) | ({AW{s_stk}} & stk);
      end
   endgenerate
endmodule

// File: rtl/branch_addr_unit.sv
module branch_addr_unit
   import br_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int BYTE_W    = 8,
   parameter int DEPTH     = 8,
   parameter int SEL_STYLE = 0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [BYTE_W-1:0]        hl_h,
   input  logic [BYTE_W-1:0]        hl_l,
   input  logic [BYTE_W-1:0]        inl_byte,
   input  logic                     inl_lo_we,
   input  logic                     inl_hi_we,
   input  logic [ADDR_W-1:0]        pc_in,
   input  logic                     push_req,
   input  logic                     pop_req,
   input  logic [1:0]               src_sel,
   input  logic                     load_en,
   output logic [ADDR_W-1:0]        addr_out,
   output logic [$clog2(DEPTH)-1:0] stk_ptr
);
   localparam int HI_W = ADDR_W - BYTE_W;
   localparam int PW   = $clog2(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("branch_addr_unit: DEPTH must be at least 2");
      end
      if (HI_W < 1 || HI_W > BYTE_W) begin : g_bad_width
         $error("branch_addr_unit: ADDR_W must lie between BYTE_W+1 and 2*BYTE_W");
      end
      if (SEL_STYLE != 0 && SEL_STYLE != 1) begin : g_bad_style
         $error("branch_addr_unit: SEL_STYLE must be 0 or 1");
      end
   endgenerate

   logic [ADDR_W-1:0] hl_addr, tmp_addr, stk_top, nxt_addr;
   logic              take;

   assign hl_addr = {hl_h[HI_W-1:0], hl_l};

   br_tmp_addr #(.AW(ADDR_W), .BW(BYTE_W)) u_tmp (
      .clk     (clk),
      .byte_in (inl_byte),
      .lo_we   (inl_lo_we),
      .hi_we   (inl_hi_we),
      .value   (tmp_addr)
   );

   br_ret_stack #(.AW(ADDR_W), .DEPTH(DEPTH), .PW(PW)) u_stk (
      .clk   (clk),
      .rst   (rst),
      .push  (push_req),
      .pop   (pop_req),
      .wdata (pc_in),
      .top   (stk_top),
      .ptr   (stk_ptr)
   );

   br_src_mux #(.AW(ADDR_W), .STYLE(SEL_STYLE)) u_mux (
      .sel  (src_sel_e'(src_sel)),
      .hl   (hl_addr),
      .tmp  (tmp_addr),
      .stk  (stk_top),
      .nxt  (nxt_addr),
      .take (take)
   );

   always_ff @(posedge clk) begin
      if (rst) addr_out <= '0;
      else if (load_en && take) addr_out <= nxt_addr;
   end
endmodule

// File: rtl/br_addr_chk.sv
module br_addr_chk #(
   parameter int ADDR_W = 13,
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 8
) (
   input logic                     clk,
   input logic                     rst,
   input logic [BYTE_W-1:0]        hl_h,
   input logic [BYTE_W-1:0]        hl_l,
   input logic [ADDR_W-1:0]        pc_in,
   input logic                     push_req,
   input logic                     pop_req,
   input logic [1:0]               src_sel,
   input logic                     load_en,
   input logic [ADDR_W-1:0]        addr_out,
   input logic [$clog2(DEPTH)-1:0] stk_ptr
);
   localparam int HI_W = ADDR_W - BYTE_W;
   localparam int PW   = $clog2(DEPTH);

   function automatic logic [PW-1:0] up(input logic [PW-1:0] p);
      return PW'((int'(p) + 1) % DEPTH);
   endfunction
   function automatic logic [PW-1:0] dn(input logic [PW-1:0] p);
      return PW'((int'(p) + DEPTH - 1) % DEPTH);
   endfunction

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (addr_out == '0 && stk_ptr == '0));

   assert_hl_load_R2: assert property (@(posedge clk) disable iff (rst)
      (load_en && src_sel == 2'b00) |=> addr_out == {$past(hl_h[HI_W-1:0]), $past(hl_l)});

   assert_push_step_R4: assert property (@(posedge clk) disable iff (rst)
      (push_req && !pop_req) |=> stk_ptr == up($past(stk_ptr)));

   assert_idle_ptr_R4: assert property (@(posedge clk) disable iff (rst)
      (!push_req && !pop_req) |=> $stable(stk_ptr));

   assert_pop_step_R5: assert property (@(posedge clk) disable iff (rst)
      (pop_req && !push_req) |=> stk_ptr == dn($past(stk_ptr)));

   assert_call_return_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(push_req) && !push_req && load_en && src_sel == 2'b10)
      |=> addr_out == $past(pc_in, 2));

   assert_top_wrap_R6: assert property (@(posedge clk) disable iff (rst)
      (push_req && stk_ptr == PW'(DEPTH - 1)) |=> stk_ptr == '0);

   assert_push_wins_R7: assert property (@(posedge clk) disable iff (rst)
      (push_req && pop_req) |=> stk_ptr == up($past(stk_ptr)));

   assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!load_en || src_sel == 2'b11) |=> $stable(addr_out));
endmodule

bind branch_addr_unit br_addr_chk #(
   .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH)
) u_chk (
   .clk(clk), .rst(rst), .hl_h(hl_h), .hl_l(hl_l), .pc_in(pc_in),
   .push_req(push_req), .pop_req(pop_req), .src_sel(src_sel),
   .load_en(load_en), .addr_out(addr_out), .stk_ptr(stk_ptr)
);

// File: tb/test_branch_addr_unit.sv
module test_branch_addr_unit;
   localparam int AW = 13;
   localparam int BW = 8;
   localparam int DEPTH = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [BW-1:0] hl_h = '0, hl_l = '0, inl_byte = '0;
   logic          inl_lo_we = 1'b0, inl_hi_we = 1'b0;
   logic [AW-1:0] pc_in = '0;
   logic          push_req = 1'b0, pop_req = 1'b0, load_en = 1'b0;
   logic [1:0]    src_sel = 2'b11;
   logic [AW-1:0] addr_out;
   logic [2:0]    stk_ptr;

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_req = "R1";

   int ref_mem [DEPTH];
   int ref_ptr = 0, ref_addr = 0, ref_lo = 0, ref_hi = 0;

   always #2 clk = ~clk;

   branch_addr_unit i_branch_addr_unit (
      .clk(clk), .rst(rst), .hl_h(hl_h), .hl_l(hl_l), .inl_byte(inl_byte),
      .inl_lo_we(inl_lo_we), .inl_hi_we(inl_hi_we), .pc_in(pc_in),
      .push_req(push_req), .pop_req(pop_req), .src_sel(src_sel),
      .load_en(load_en), .addr_out(addr_out), .stk_ptr(stk_ptr)
   );

   // Behavioural reference, updated on each rising edge from pre-edge inputs
   always @(posedge clk) begin
      int top, tmp;
      if (rst) begin
         ref_ptr = 0;
         ref_addr = 0;
      end else begin
         top = ref_mem[(ref_ptr + DEPTH - 1) % DEPTH];
         tmp = ref_hi * 256 + ref_lo;
         if (load_en) begin
            if (src_sel == 2'b00) ref_addr = (int'(hl_h) % 32) * 256 + int'(hl_l);
            else if (src_sel == 2'b01) ref_addr = tmp;
            else if (src_sel == 2'b10) ref_addr = top;
         end
         if (push_req) begin
            ref_mem[ref_ptr] = int'(pc_in);
            ref_ptr = (ref_ptr + 1) % DEPTH;
         end else if (pop_req) begin
            ref_ptr = (ref_ptr + DEPTH - 1) % DEPTH;
         end
      end
      if (inl_lo_we) ref_lo = int'(inl_byte);
      if (inl_hi_we) ref_hi = int'(inl_byte) % 32;
   end

   task automatic check(input int act, input int exp, input string what);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      check(int'(addr_out), ref_addr, "addr_out");
      check(int'(stk_ptr), ref_ptr, "stk_ptr");
   endtask

   task automatic idle();
      push_req = 0; pop_req = 0; load_en = 0; src_sel = 2'b11;
      inl_lo_we = 0; inl_hi_we = 0;
   endtask

   initial begin
      int wd = 0;
      while (wd < 100000) begin
         @(posedge clk);
         wd++;
      end
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 0;
      @(negedge clk);
      // R1: reset state
      cur_req = "R1";
      tick(); tick();
      check(int'(addr_out), 0, "reset addr");
      rst = 0;

      // R2: H/L source, upper H bits dropped
      cur_req = "R2";
      hl_h = 8'hFF; hl_l = 8'h34; load_en = 1; src_sel = 2'b00; tick();
      check(int'(addr_out), 'h1F34, "H/L load");
      hl_h = 8'h0A; hl_l = 8'hC5; tick();
      check(int'(addr_out), 'h0AC5, "H/L load 2");

      // R8: hold when disabled or select 11
      cur_req = "R8";
      idle(); hl_h = 8'h12; hl_l = 8'h34; src_sel = 2'b00; tick(); tick();
      check(int'(addr_out), 'h0AC5, "hold load_en low");
      load_en = 1; src_sel = 2'b11; tick();
      check(int'(addr_out), 'h0AC5, "hold select 11");

      // R3: temporary register capture, low then high
      cur_req = "R3";
      idle(); inl_byte = 8'h78; inl_lo_we = 1; tick();
      inl_lo_we = 0; inl_hi_we = 1; inl_byte = 8'hF5; tick();
      check(int'(addr_out), 'h0AC5, "strobes leave addr");
      inl_hi_we = 0; load_en = 1; src_sel = 2'b01; tick();
      check(int'(addr_out), 'h1578, "temp load");
      // load same edge as a low write sees the old value
      inl_lo_we = 1; inl_byte = 8'h9A; tick();
      check(int'(addr_out), 'h1578, "temp old value");
      inl_lo_we = 0; tick();
      check(int'(addr_out), 'h159A, "high half kept");

      // R4: pushes
      cur_req = "R4";
      idle();
      for (int k = 0; k < 3; k++) begin
         pc_in = AW'(13'h0100 + k * 13'h0111); push_req = 1; tick();
      end
      idle(); tick();
      check(int'(stk_ptr), 3, "ptr after 3 pushes");

      // R5: pops return last-in first
      cur_req = "R5";
      pop_req = 1; load_en = 1; src_sel = 2'b10; tick();
      check(int'(addr_out), 'h0322, "first return");
      tick();
      check(int'(addr_out), 'h0211, "second return");

      // R7: push and pop together
      cur_req = "R7";
      pc_in = 13'h1ABC; push_req = 1; pop_req = 1; tick();
      check(int'(stk_ptr), 2, "push wins");
      check(int'(addr_out), 'h0100, "pre-push top read");
      idle(); pop_req = 1; load_en = 1; src_sel = 2'b10; tick();
      check(int'(addr_out), 'h1ABC, "pushed entry returned");

      // R1: reset mid-run
      cur_req = "R1";
      idle(); rst = 1; tick();
      check(int'(stk_ptr), 0, "reset ptr");
      rst = 0;

      // R6: wrap after nine pushes, pop from 0 to 7
      cur_req = "R6";
      for (int k = 0; k < 9; k++) begin
         pc_in = AW'(13'h0040 + k); push_req = 1; tick();
      end
      idle(); tick();
      check(int'(stk_ptr), 1, "ptr wrapped");
      pop_req = 1; load_en = 1; src_sel = 2'b10; tick();
      check(int'(addr_out), 'h0048, "overwritten entry 0");
      tick();
      check(int'(stk_ptr), 7, "pop below zero");
      check(int'(addr_out), 'h0047, "entry 7");
      idle(); tick();

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule